// File: doc/BRIEF.md
# Packed-Byte Video ALU

This block is a registered datapath for pixel work on 32-bit words. A word holds either four unsigned bytes or two signed 16-bit halves. Each cycle with a valid operation, the block applies one of several lane-wise operations to two source words and registers the 32-bit result. The operations are:

- a byte window taken from a word pair
- byte packing
- 8-bit and 16-bit adds that clip to the lane range
- a byte average, rounded or truncated

A motion-estimation operation leaves the result alone. It takes the absolute difference of each byte pair and adds it into one of four saturating accumulators, one per byte lane. A separate clear input zeroes all four accumulators in one cycle.

The caller drives `op`, `sel_off`, `src_a` and `src_b` together with `op_valid`. The result appears on `result` after the next rising clock edge. `acc_q` always shows the four accumulators.

Top module: `pkvid_alu`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `result` and `acc_q` are zero.
- R2: Opcode 0 (window) returns bytes `sel_off` through `sel_off`+3 of the 64-bit value {`src_b`,`src_a`}. Byte 0 is `src_a[7:0]` and byte 7 is `src_b[31:24]`. The chosen bytes keep their order, with the lowest-numbered byte in `result[7:0]`.
- R3: Opcode 1 (pack) gives `result` = {`src_b[23:16]`, `src_b[7:0]`, `src_a[23:16]`, `src_a[7:0]`}. This is the low byte of each 16-bit half.
- R4: Opcode 2 adds the four byte lanes as unsigned values. A sum above 255 gives 0xFF in that lane, and lanes do not affect each other.
- R5: Opcode 3 adds the two 16-bit halves as signed values. A sum above 32767 gives 0x7FFF and a sum below -32768 gives 0x8000.
- R6: Opcode 4 gives (a+b+1)>>1 per byte lane, computed without loss of the carry.
- R7: Opcode 5 gives (a+b)>>1 per byte lane.
- R8: Opcode 6 adds |a-b| of byte lane i into accumulator i. Accumulator i sits at `acc_q[16i+15:16i]`.
- R9: An accumulator that would pass 0xFFFF stays at 0xFFFF.
- R10: A cycle with `acc_clear` high zeroes all four accumulators. This takes priority over an opcode 6 in the same cycle.
- R11: `result` keeps its value when `op_valid` is low, for opcode 6, and for opcode 7. The accumulators change only through opcode 6 and `acc_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code, 0 to 7 |
| sel_off | input | 2 | Byte offset for the window operation |
| src_a | input | 32 | First source word (low word of the window pair) |
| src_b | input | 32 | Second source word (high word of the window pair) |
| acc_clear | input | 1 | Zero all accumulators |
| result | output | 32 | Registered result |
| acc_q | output | 64 | Four 16-bit accumulators, lane 0 in the low bits |

## Verification
The saturation point of an accumulator is the hardest state to reach from the ports, because every step adds at most 255. The bench clears the accumulators and then issues opcode 6 with a single lane differing by 0xFF. After 256 operations that lane must read 0xFF00. After 257 operations it lands exactly on 0xFFFF. One more operation must leave it there. The same sequence also shows that the other lanes, and `result`, stay untouched throughout.

// File: rtl/pkvid_alu.sv
module pkvid_alu #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op,
  input  logic [1:0]       sel_off,
  input  logic [31:0]      src_a,
  input  logic [31:0]      src_b,
  input  logic             acc_clear,
  output logic [31:0]      result,
  output logic [4*ACC_W-1:0] acc_q
);

  localparam int LANES = 4;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [63:0] pair;
  logic [63:0] shifted;
  logic [31:0] add8, avg_r, avg_t, add16, pack_w, nxt_res;
  logic [4*ACC_W-1:0] nxt_acc;
  logic res_upd, saa_go;

  assign pair    = {src_b, src_a};
  assign shifted = pair >> (8 * sel_off);
  assign pack_w  = {src_b[23:16], src_b[7:0], src_a[23:16], src_a[7:0]};
  assign saa_go  = op_valid && op == 3'd6;
  assign res_upd = op_valid && op != 3'd6 && op != 3'd7;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [8:0] s9, s9r;
      logic [7:0] d8;
      logic [ACC_W:0] sum;
      s9  = {1'b0, src_a[8*i +: 8]} + {1'b0, src_b[8*i +: 8]};
      s9r = s9 + 9'd1;
      add8[8*i +: 8]  = s9[8] ? 8'hFF : s9[7:0];
      avg_r[8*i +: 8] = s9r[8:1];
      avg_t[8*i +: 8] = s9[8:1];
      d8 = (src_a[8*i +: 8] > src_b[8*i +: 8]) ? src_a[8*i +: 8] - src_b[8*i +: 8]
                                               : src_b[8*i +: 8] - src_a[8*i +: 8];
      sum = {1'b0, acc_q[ACC_W*i +: ACC_W]} + (ACC_W+1)'(d8);
      nxt_acc[ACC_W*i +: ACC_W] = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
    end
    for (int j = 0; j < 2; j++) begin
      logic [15:0] ha, hb, hs;
      ha = src_a[16*j +: 16];
      hb = src_b[16*j +: 16];
      hs = ha + hb;
      if (ha[15] == hb[15] && hs[15] != ha[15])
        add16[16*j +: 16] = ha[15] ? 16'h8000 : 16'h7FFF;
      else
        add16[16*j +: 16] = hs;
    end
  end

  always_comb begin
    case (op)
      3'd0:    nxt_res = shifted[31:0];
      3'd1:    nxt_res = pack_w;
      3'd2:    nxt_res = add8;
      3'd3:    nxt_res = add16;
      3'd4:    nxt_res = avg_r;
      3'd5:    nxt_res = avg_t;
      default: nxt_res = result;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      acc_q  <= '0;
    end else begin
      if (res_upd) result <= nxt_res;
      if (acc_clear) acc_q <= '0;
      else if (saa_go) acc_q <= nxt_acc;
    end
  end

  assert_acc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> acc_q == '0);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !acc_clear) |=> ($stable(acc_q) && $stable(result)));

  assert_saa_keeps_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd6) |=> $stable(result));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_acc_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 3'd6 && !acc_clear)
        |=> acc_q[ACC_W*g +: ACC_W] >= $past(acc_q[ACC_W*g +: ACC_W]));
    assert_acc_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 3'd6 && !acc_clear && acc_q[ACC_W*g +: ACC_W] == ACC_MAX)
        |=> acc_q[ACC_W*g +: ACC_W] == ACC_MAX);
  end

endmodule

// File: tb/pkvid_alu_tb.sv
module pkvid_alu_tb;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  off;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 32'h33221100, 32'h77665544, 32'h33221100},  // R2 offset 0
    '{3'd0, 2'd1, 32'h33221100, 32'h77665544, 32'h44332211},  // R2 offset 1
    '{3'd0, 2'd3, 32'h33221100, 32'h77665544, 32'h66554433},  // R2 offset 3
    '{3'd1, 2'd0, 32'hAABBCCDD, 32'h11223344, 32'h2244BBDD},  // R3
    '{3'd2, 2'd0, 32'h80FF1001, 32'h80012002, 32'hFFFF3003},  // R4
    '{3'd3, 2'd0, 32'h7FFF8000, 32'h0001FFFF, 32'h7FFF8000},  // R5 both limits
    '{3'd3, 2'd0, 32'h1234FFFE, 32'h01000003, 32'h13340001},  // R5 no clip
    '{3'd4, 2'd0, 32'h01FF0300, 32'h00FE0401, 32'h01FF0401},  // R6
    '{3'd5, 2'd0, 32'h01FF0300, 32'h00FE0401, 32'h00FE0300}   // R7
  };

  logic clk = 0, rst_n = 0, op_valid = 0, acc_clear = 0;
  logic [2:0] op = '0;
  logic [1:0] sel_off = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] result;
  logic [63:0] acc_q;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pkvid_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .sel_off(sel_off),
    .src_a(src_a), .src_b(src_b), .acc_clear(acc_clear),
    .result(result), .acc_q(acc_q)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] o, input logic [1:0] k,
                       input logic [31:0] a, input logic [31:0] b, input logic clr);
    @(negedge clk);
    op_valid = v; op = o; sel_off = k; src_a = a; src_b = b; acc_clear = clr;
    @(posedge clk);
    #1;
    op_valid = 0; acc_clear = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result in reset", {32'h0, result}, 64'h0);
    check("R1 acc in reset", acc_q, 64'h0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 result after reset", {32'h0, result}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i].op, VEC[i].off, VEC[i].a, VEC[i].b, 1'b0);
      check($sformatf("R%0s vector %0d", "", i), {32'h0, result}, {32'h0, VEC[i].exp});
    end

    // R11: idle cycle and opcode 7 keep result (last was 0x00FE0300)
    issue(1'b0, 3'd2, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
    check("R11 idle holds result", {32'h0, result}, 64'h00FE0300);
    issue(1'b1, 3'd7, 2'd0, 32'h12345678, 32'h9ABCDEF0, 1'b0);
    check("R11 opcode 7 holds result", {32'h0, result}, 64'h00FE0300);
    check("R11 opcode 7 keeps acc", acc_q, 64'h0);

    // R8: two accumulate steps
    issue(1'b1, 3'd6, 2'd0, 32'h1000FF05, 32'h05100005, 1'b0);
    check("R8 first accumulate", acc_q, 64'h000B_0010_00FF_0000);
    check("R11 accumulate keeps result", {32'h0, result}, 64'h00FE0300);
    issue(1'b1, 3'd6, 2'd0, 32'h1000FF05, 32'h05100005, 1'b0);
    check("R8 second accumulate", acc_q, 64'h0016_0020_01FE_0000);

    // R10: clear wins over accumulate
    issue(1'b1, 3'd6, 2'd0, 32'hFFFFFFFF, 32'h0, 1'b1);
    check("R10 clear over accumulate", acc_q, 64'h0);

    // R9: lane 0 steps of 0xFF up to saturation
    for (int n = 0; n < 256; n++)
      issue(1'b1, 3'd6, 2'd0, 32'h000000FF, 32'h0, 1'b0);
    check("R9 after 256 steps", acc_q, 64'h0000_0000_0000_FF00);
    issue(1'b1, 3'd6, 2'd0, 32'h000000FF, 32'h0, 1'b0);
    check("R9 exact max", acc_q, 64'h0000_0000_0000_FFFF);
    issue(1'b1, 3'd6, 2'd0, 32'h000000FF, 32'h0, 1'b0);
    check("R9 stays saturated", acc_q, 64'h0000_0000_0000_FFFF);
    check("R11 result unchanged by accumulate", {32'h0, result}, 64'h00FE0300);

    // R10: plain clear
    issue(1'b0, 3'd0, 2'd0, 32'h0, 32'h0, 1'b1);
    check("R10 clear", acc_q, 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule